// File: doc/BRIEF.md
# Self-Clocked Serial Result Port

This block is the output stage of a converter that supplies its own serial clock. A new 16-bit result is offered on a parallel word input together with a one-cycle load strobe. The block then opens a frame of a fixed 32 internal clocks. The first cycle of the frame is a one-cycle ready pulse, and this pulse also acts as the receiver's frame sync. The block then shifts the word out most significant bit first on a serial data line, with a serial clock it generates at half the internal clock rate.

Data launches on each rising edge of the serial clock, so a receiver samples it on the falling edges. A result that arrives while a frame is in progress waits in a holding register. It starts the next frame as soon as the current one ends, so the word on the wire is never disturbed. Frame cycles are counted from 0, the cycle in which ready is high, up to 31.

Top module: `srp_port`

## Requirements
- R1: While reset is asserted, and after its release until the first result is loaded, ready, serial clock and serial data are all 0. Asserting reset forces them to 0 at once, without waiting for a clock edge.
- R2: When the block is idle, a load strobe sampled on one rising clock edge makes ready high from the next rising edge. Ready is high for exactly one cycle (frame cycle 0) and low in frame cycles 1 to 31.
- R3: Two ready pulses are always at least 32 cycles apart. When a result is waiting at the end of a frame, the next ready pulse comes exactly 32 cycles after the previous one.
- R4: Serial clock is 0 in frame cycle 0, 1 in the odd frame cycles 1 to 31, and 0 in the even ones. It stays 0 whenever no frame is running.
- R5: Bit 15-k of the loaded word is on serial data during frame cycles 2k+1 and 2k+2, for k = 0 to 15. Bit 15 (the MSB) goes first.
- R6: Serial data changes only together with a rising serial clock. After the last bit it keeps bit 0 until the first bit of the next frame.
- R7: A strobe during a running frame, or a change of the word input without a strobe, leaves the bits of the current frame unaffected. A held word starts the next frame straight after frame cycle 31.
- R8: When several strobes arrive within one frame, only the word of the last strobe is sent, and it is sent in a single frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| res_word | input | 16 | Result word to transmit |
| res_load | input | 1 | One-cycle strobe: res_word holds a new result |
| frame_rdy | output | 1 | One-cycle ready pulse at frame start, also the frame sync |
| ser_clk | output | 1 | Generated serial clock, half the internal rate |
| ser_dat | output | 1 | Serial data, MSB first, changes on rising ser_clk |

## Verification
A wrong frame counter shows at the ports within one frame. The serial clock phase would be off against the ready pulse, or the ready spacing would differ from 32 cycles, and the bench checks both in every cycle of every frame. A wrong shift register or holding register shows as a wrong decoded word at the end of that frame. This includes a word overwritten by a strobe that arrives mid-frame, or a frame that is sent twice. Data that moves at a time other than a rising serial clock shows as a mismatch in the even frame cycles, and the bench compares the data in each of those cycles with the value it had in the cycle before.

// File: rtl/srp_pkg.sv
package srp_pkg;

  // Frame engine phase
  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_RUN  = 1'b1
  } srp_phase_e;

endpackage

// File: rtl/srp_rst_sync.sv
module srp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);

  logic [1:0] sync_q;

  // Assert at once, release after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_s_n = sync_q[1];

endmodule

// File: rtl/srp_hold.sv
module srp_hold #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] word,
  input  logic              take,
  output logic [WORD_W-1:0] pend_word,
  output logic              pend_valid
);

  logic [WORD_W-1:0] word_q, word_n;
  logic              valid_q, valid_n;
  logic              word_en;

  // A fresh strobe overrides any older word. A take in the same cycle
  // consumes the old word while the new one stays pending.
  always_comb begin
    word_en = load;
    word_n  = word;
    if (load) begin
      valid_n = 1'b1;
    end else if (take) begin
      valid_n = 1'b0;
    end else begin
      valid_n = valid_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_n;
      if (word_en) begin
        word_q <= word_n;
      end
    end
  end

  assign pend_word  = word_q;
  assign pend_valid = valid_q;

  AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (!rst_n) (valid_q && !load && !take) |=> (valid_q && $stable(word_q))); // R7
  AST_LAST_STROBE_KEPT: assert property (@(posedge clk) disable iff (!rst_n) load |=> (valid_q && word_q == $past(word))); // R8

endmodule

// File: rtl/srp_timer.sv
module srp_timer
  import srp_pkg::*;
#(
  parameter int FRAME_LEN = 32,
  parameter int WORD_W    = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pend_valid,
  output logic start,
  output logic shift_en,
  output logic rdy,
  output logic sclk
);

  localparam int CNT_W     = $clog2(FRAME_LEN);
  localparam int LAST      = FRAME_LEN - 1;
  localparam int LAST_RISE = 2 * WORD_W - 1;

  srp_phase_e       ph_q, ph_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             rdy_q, rdy_n;
  logic             sclk_q, sclk_n;
  logic             at_end;
  logic             start_c;
  logic             shift_c;

  assign at_end  = (ph_q == PH_RUN) && (cnt_q == CNT_W'(LAST));
  assign start_c = pend_valid && ((ph_q == PH_IDLE) || at_end);

  // Next-state logic
  always_comb begin
    ph_n    = ph_q;
    cnt_n   = cnt_q;
    rdy_n   = 1'b0;
    shift_c = 1'b0;
    if (start_c) begin
      ph_n  = PH_RUN;
      cnt_n = '0;
      rdy_n = 1'b1;
    end else if (ph_q == PH_RUN) begin
      if (at_end) begin
        ph_n  = PH_IDLE;
        cnt_n = '0;
      end else begin
        cnt_n   = cnt_q + 1'b1;
        shift_c = cnt_n[0] && (cnt_n <= CNT_W'(LAST_RISE));
      end
    end else begin
      cnt_n = '0;
    end
    sclk_n = shift_c;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      rdy_q  <= 1'b0;
      sclk_q <= 1'b0;
    end else begin
      ph_q   <= ph_n;
      cnt_q  <= cnt_n;
      rdy_q  <= rdy_n;
      sclk_q <= sclk_n;
    end
  end

  assign start    = start_c;
  assign shift_en = shift_c;
  assign rdy      = rdy_q;
  assign sclk     = sclk_q;

  // Spacing monitor: cycles since the last ready pulse, saturating
  logic [CNT_W:0] gap_q;
  logic           seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (rdy_q) begin
      gap_q  <= '0;
      seen_q <= 1'b1;
    end else if (gap_q != (CNT_W+1)'(FRAME_LEN)) begin
      gap_q <= gap_q + 1'b1;
    end
  end

  AST_RDY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) rdy_q |=> !rdy_q); // R2
  AST_FRAME_GAP: assert property (@(posedge clk) disable iff (!rst_n) (rdy_q && seen_q) |-> (gap_q >= (CNT_W+1)'(LAST))); // R3
  AST_RDY_SCLK_LOW: assert property (@(posedge clk) disable iff (!rst_n) rdy_q |-> !sclk_q); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (ph_q == PH_IDLE) |-> (!sclk_q && !rdy_q)); // R4
  AST_START_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n) start_c |-> !shift_c); // R7

endmodule

// File: rtl/srp_shifter.sv
module srp_shifter #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] word,
  input  logic              shift_en,
  output logic              sdo
);

  localparam int BCNT_W = $clog2(WORD_W) + 1;

  logic [WORD_W-1:0] sreg_q, sreg_n;
  logic              sdo_q, sdo_n;
  logic              reg_en;

  // Next-state: load at frame start, shift on each rising serial clock
  always_comb begin
    reg_en = start || shift_en;
    sreg_n = sreg_q;
    sdo_n  = sdo_q;
    if (start) begin
      sreg_n = word;
    end else if (shift_en) begin
      sdo_n  = sreg_q[WORD_W-1];
      sreg_n = {sreg_q[WORD_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '0;
      sdo_q  <= 1'b0;
    end else if (reg_en) begin
      sreg_q <= sreg_n;
      sdo_q  <= sdo_n;
    end
  end

  assign sdo = sdo_q;

  // Bits sent since the last frame start
  logic [BCNT_W-1:0] sent_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sent_q <= '0;
    end else if (start) begin
      sent_q <= '0;
    end else if (shift_en) begin
      sent_q <= sent_q + 1'b1;
    end
  end

  AST_BITS_PER_FRAME: assert property (@(posedge clk) disable iff (!rst_n) shift_en |-> (sent_q < BCNT_W'(WORD_W))); // R5

endmodule

// File: rtl/srp_port.sv
module srp_port #(
  parameter int WORD_W    = 16,
  parameter int FRAME_LEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] res_word,
  input  logic              res_load,
  output logic              frame_rdy,
  output logic              ser_clk,
  output logic              ser_dat
);

  logic              rst_s_n;
  logic [WORD_W-1:0] pend_word;
  logic              pend_valid;
  logic              start;
  logic              shift_en;

  srp_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  srp_hold #(.WORD_W(WORD_W)) u_hold (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .load       (res_load),
    .word       (res_word),
    .take       (start),
    .pend_word  (pend_word),
    .pend_valid (pend_valid)
  );

  srp_timer #(.FRAME_LEN(FRAME_LEN), .WORD_W(WORD_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .pend_valid (pend_valid),
    .start      (start),
    .shift_en   (shift_en),
    .rdy        (frame_rdy),
    .sclk       (ser_clk)
  );

  srp_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .start    (start),
    .word     (pend_word),
    .shift_en (shift_en),
    .sdo      (ser_dat)
  );

  AST_DATA_ON_RISE: assert property (@(posedge clk) disable iff (!rst_s_n) !$rose(ser_clk) |-> $stable(ser_dat)); // R6

endmodule

// File: tb/tb_srp_port.sv
module tb_srp_port;

  localparam int CLK_PERIOD = 10;
  localparam int W = 16;
  localparam int F = 32;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] res_word;
  logic         res_load;
  logic         frame_rdy;
  logic         ser_clk;
  logic         ser_dat;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  srp_port #(.WORD_W(W), .FRAME_LEN(F)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .res_word  (res_word),
    .res_load  (res_load),
    .frame_rdy (frame_rdy),
    .ser_clk   (ser_clk),
    .ser_dat   (ser_dat)
  );

  localparam logic [W-1:0] VEC [8] = '{16'h8001, 16'hFFFF, 16'h0000, 16'hA5C3,
                                       16'h1234, 16'h7FFE, 16'h5555, 16'hC0DE};

  task automatic chk_eq(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Strobe a word while idle; returns at the negedge of frame cycle 0
  task automatic start_frame(input logic [W-1:0] w);
    @(negedge clk);
    res_word = w;
    res_load = 1'b1;
    @(negedge clk);
    res_load = 1'b0;
    chk_eq("R2", "ready not yet high one cycle after strobe", int'(frame_rdy), 0);
    @(negedge clk);
    chk_eq("R2", "ready high at frame start", int'(frame_rdy), 1);
    chk_eq("R4", "sclk low in frame cycle 0", int'(ser_clk), 0);
  endtask

  // Walk frame cycles 1..31 from cycle 0; optional strobes at given cycles
  task automatic run_frame(input int c1, input logic [W-1:0] w1,
                           input int c2, input logic [W-1:0] w2,
                           output logic [W-1:0] got);
    logic prev;
    got  = '0;
    prev = ser_dat;
    for (int c = 1; c < F; c++) begin
      @(negedge clk);
      chk_eq("R2", "ready low inside frame", int'(frame_rdy), 0);
      chk_eq("R4", "sclk phase in frame", int'(ser_clk), c % 2);
      if ((c % 2) == 1) begin
        got[W-1-(c-1)/2] = ser_dat;
      end else begin
        chk_eq("R6", "data held while sclk low", int'(ser_dat), int'(prev));
      end
      prev     = ser_dat;
      res_load = (c == c1) || (c == c2);
      res_word = (c == c2) ? w2 : w1;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [W-1:0] got;
    rst_n    = 1'b0;
    res_load = 1'b0;
    res_word = '0;
    repeat (3) @(negedge clk);
    chk_eq("R1", "ready in reset", int'(frame_rdy), 0);
    chk_eq("R1", "sclk in reset", int'(ser_clk), 0);
    chk_eq("R1", "data in reset", int'(ser_dat), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk_eq("R1", "ready idle after reset", int'(frame_rdy), 0);
    chk_eq("R1", "sclk idle after reset", int'(ser_clk), 0);
    chk_eq("R1", "data idle after reset", int'(ser_dat), 0);

    // Vector table: each word sent alone, decoded and compared
    for (int i = 0; i < 8; i++) begin
      start_frame(VEC[i]);
      run_frame(-1, '0, -1, '0, got);
      chk_eq("R5", "decoded word MSB first", int'(got), int'(VEC[i]));
      @(negedge clk);
      chk_eq("R3", "no new frame without strobe", int'(frame_rdy), 0);
      chk_eq("R4", "sclk idle after frame", int'(ser_clk), 0);
      chk_eq("R6", "last bit held after frame", int'(ser_dat), int'(VEC[i][0]));
      repeat (3) @(negedge clk);
      chk_eq("R6", "last bit still held when idle", int'(ser_dat), int'(VEC[i][0]));
      chk_eq("R4", "sclk stays low when idle", int'(ser_clk), 0);
    end

    // Mid-frame strobes: current word intact, last strobe wins, back to back
    start_frame(16'h3C96);
    run_frame(9, 16'hDEAD, 21, 16'h0F1E, got);
    chk_eq("R7", "frame in flight not corrupted", int'(got), 16'h3C96);
    @(negedge clk);
    chk_eq("R3", "held word starts 32 cycles after previous ready", int'(frame_rdy), 1);
    chk_eq("R4", "sclk low at back-to-back start", int'(ser_clk), 0);
    run_frame(-1, '0, -1, '0, got);
    chk_eq("R8", "last strobed word sent", int'(got), 16'h0F1E);
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (frame_rdy) chk_eq("R8", "only one frame for held word", 1, 0);
    end
    chk_eq("R8", "ready low after single held frame", int'(frame_rdy), 0);

    // Reset in mid-frame forces outputs low at once
    start_frame(16'hFFFF);
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk_eq("R1", "ready cleared by reset mid-frame", int'(frame_rdy), 0);
    chk_eq("R1", "sclk cleared by reset mid-frame", int'(ser_clk), 0);
    chk_eq("R1", "data cleared by reset mid-frame", int'(ser_dat), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk_eq("R1", "ready idle after second reset", int'(frame_rdy), 0);
    chk_eq("R1", "data idle after second reset", int'(ser_dat), 0);
    start_frame(16'h6B2D);
    run_frame(-1, '0, -1, '0, got);
    chk_eq("R5", "word after reset recovery", int'(got), 16'h6B2D);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule